// File: doc/BRIEF.md
# Misaligned Access Bus Cycle Splitter

This block sits between a requester and a 32-bit memory bus. The requester issues byte, word or longword reads and writes at any address. The bus accepts only naturally aligned cycles. An access that the bus can take as it stands passes through as one bus cycle. A misaligned access is broken into a short, fixed sequence of smaller aligned cycles, issued in increasing address order.

Byte order is big-endian: the byte at the lowest address is the most significant. For writes, each sub-cycle carries the request bytes that fall on its own addresses. For reads, the sub-cycle results are shifted together into one right-justified value. The requester sees a single completion pulse, and it comes only after the last sub-cycle has finished on the bus. Wait states come from the bus handshake. Arbitration is handled elsewhere.

Top module: `acc_splitter`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low from the edge after acceptance until the cycle in which `done_o` is high, and it is low whenever `bus_valid_o` is high.
- R2: A byte access (`req_size_i` = 0) at any address produces exactly one byte bus cycle (`bus_size_o` = 0) at the request address.
- R3: A word (size code 1) at an even address, or a longword (size code 2) at an address with its two low bits zero, produces one bus cycle of the same size at the request address.
- R4: A word at an odd address produces two byte cycles, at A and then A+1.
- R5: A longword at an address of the form 4n+2 produces two word cycles, at A and then A+2.
- R6: A longword at an odd address produces three cycles: a byte at A, a word at A+1 and a byte at A+3.
- R7: On reads, bus data is right-justified and the bits above the cycle size are ignored. The cycle results are concatenated in address order. `rdata_o` holds the zero-extended big-endian value (the lowest address is the most significant) while `done_o` is high.
- R8: On writes, `bus_wdata_o` carries, right-justified, the bytes of the right-justified `req_wdata_i` that map big-endian onto the cycle's addresses, with zero above them. On reads, `bus_wdata_o` is zero.
- R9: While `bus_valid_o` is high and `bus_ready_i` is low, `bus_addr_o`, `bus_size_o`, `bus_we_o` and `bus_wdata_o` hold steady. A cycle completes on an edge where both are high.
- R10: `done_o` pulses for one cycle, in the cycle after the last bus cycle of the access completes. After a write, `rdata_o` is zero during that pulse.
- R11: Every bus cycle is naturally aligned: words at even addresses and longwords at multiples of four. `bus_size_o` is never 3.
- R12: Request size code 3 behaves exactly as a longword.
- R13: During reset `req_ready_o` is 1, `bus_valid_o` is 0 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | AW | Byte address of the access |
| req_size_i | input | 2 | 0 byte, 1 word, 2 or 3 longword |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_wdata_i | input | DW | Write data, right-justified |
| bus_valid_o | output | 1 | Bus cycle request |
| bus_ready_i | input | 1 | Bus cycle completes |
| bus_addr_o | output | AW | Bus cycle address |
| bus_size_o | output | 2 | Bus cycle size, 0 byte, 1 word, 2 longword |
| bus_we_o | output | 1 | Bus cycle is a write |
| bus_wdata_o | output | DW | Bus write data, right-justified |
| bus_rdata_i | input | DW | Bus read data, right-justified |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Assembled read data |

## Verification
The hardest case to reach is a three-cycle longword at an odd address while the bus stretches the middle cycle with wait states. Only in that situation do the shift-in of the read value and the sequencing of the pieces interact. The bus model cycles its wait count between zero and two, so the pieces of one access see different stall lengths. The model also returns filler bytes above the cycle size, so any missing mask in the assembly shows up in `rdata_o`. Data written by odd-address and 4n+2 accesses is read back with different alignments and at an address that carries past bit 7, so byte placement is checked end to end.

// File: rtl/acc_split_pkg.sv
package acc_split_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } size_e;

  typedef struct packed {
    size_e      sz;
    logic [1:0] off;
  } piece_t;

  localparam int unsigned MAX_PIECES = 3;

  typedef struct packed {
    logic [1:0]                  cnt;
    piece_t [MAX_PIECES-1:0]     p;
  } plan_t;

  function automatic int size_bytes(size_e s);
    case (s)
      SZ_BYTE: size_bytes = 1;
      SZ_WORD: size_bytes = 2;
      default: size_bytes = 4;
    endcase
  endfunction

  function automatic piece_t mk_piece(size_e s, logic [1:0] o);
    mk_piece = '{sz: s, off: o};
  endfunction
endpackage

// File: rtl/acc_split_plan.sv
module acc_split_plan
  import acc_split_pkg::*;
(
  input  logic [1:0] size_i,
  input  logic [1:0] addr_lo_i,
  output size_e      eff_o,
  output plan_t      plan_o
);
  always_comb begin
    eff_o       = (size_i == 2'd3) ? SZ_LONG : size_e'(size_i);
    plan_o      = '0;
    plan_o.cnt  = 2'd1;
    plan_o.p[0] = mk_piece(eff_o, 2'd0);
    case (eff_o)
      SZ_WORD: begin
        if (addr_lo_i[0]) begin
          plan_o.cnt  = 2'd2;
          plan_o.p[0] = mk_piece(SZ_BYTE, 2'd0);
          plan_o.p[1] = mk_piece(SZ_BYTE, 2'd1);
        end
      end
      SZ_LONG: begin
        case (addr_lo_i)
          2'd0: ;
          2'd2: begin
            plan_o.cnt  = 2'd2;
            plan_o.p[0] = mk_piece(SZ_WORD, 2'd0);
            plan_o.p[1] = mk_piece(SZ_WORD, 2'd2);
          end
          default: begin
            plan_o.cnt  = 2'd3;
            plan_o.p[0] = mk_piece(SZ_BYTE, 2'd0);
            plan_o.p[1] = mk_piece(SZ_WORD, 2'd1);
            plan_o.p[2] = mk_piece(SZ_BYTE, 2'd3);
          end
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_split_lane.sv
module acc_split_lane
  import acc_split_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  size_e          tot_i,
  input  piece_t         piece_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [DW-1:0]  rdata_i,
  input  logic [DW-1:0]  acc_i,
  output logic [DW-1:0]  wdata_o,
  output logic [DW-1:0]  acc_next_o
);
  int            nb;
  int            sb;
  int            sh;
  logic [DW-1:0] mask;

  always_comb begin
    nb   = size_bytes(tot_i);
    sb   = size_bytes(piece_i.sz);
    sh   = 8 * (nb - int'(piece_i.off) - sb);
    if (sh < 0) sh = 0;
    mask = {DW{1'b1}} >> (int'(DW) - 8 * sb);
    // big-endian: piece at offset o takes the bytes below the higher-address remainder
    wdata_o    = (wdata_i >> sh) & mask;
    acc_next_o = (acc_i << (8 * sb)) | (rdata_i & mask);
  end
endmodule

// File: rtl/acc_split_seq.sv
module acc_split_seq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       bus_ready_i,
  input  logic [1:0] cnt_i,
  output logic       busy_o,
  output logic [1:0] idx_o,
  output logic       hs_o,
  output logic       last_hs_o
);
  typedef enum logic {ST_IDLE, ST_RUN} st_e;
  st_e st_q;

  assign busy_o    = (st_q == ST_RUN);
  assign hs_o      = busy_o && bus_ready_i;
  assign last_hs_o = hs_o && (idx_o == 2'(cnt_i - 2'd1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_o <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_RUN;
          idx_o <= '0;
        end
        default: if (hs_o) begin
          if (last_hs_o) st_q <= ST_IDLE;
          else           idx_o <= idx_o + 2'd1;
        end
      endcase
    end
  end
endmodule

// File: rtl/acc_splitter.sv
module acc_splitter
  import acc_split_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_we_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          bus_valid_o,
  input  logic          bus_ready_i,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_size_o,
  output logic          bus_we_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);
  logic          accept;
  logic          busy;
  logic          hs;
  logic          last_hs;
  logic [1:0]    idx;
  size_e         eff_d, eff_q;
  plan_t         plan_d, plan_q;
  piece_t        cur;
  logic [AW-1:0] addr_q;
  logic          we_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] acc_q;
  logic [DW-1:0] acc_next;
  logic [DW-1:0] lane_wdata;

  assign accept = req_valid_i && req_ready_o;

  acc_split_plan u_plan (
    .size_i    (req_size_i),
    .addr_lo_i (req_addr_i[1:0]),
    .eff_o     (eff_d),
    .plan_o    (plan_d)
  );

  acc_split_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .bus_ready_i (bus_ready_i),
    .cnt_i       (plan_q.cnt),
    .busy_o      (busy),
    .idx_o       (idx),
    .hs_o        (hs),
    .last_hs_o   (last_hs)
  );

  always_comb begin
    case (idx)
      2'd0:    cur = plan_q.p[0];
      2'd1:    cur = plan_q.p[1];
      default: cur = plan_q.p[2];
    endcase
  end

  acc_split_lane #(.DW(DW)) u_lane (
    .tot_i      (eff_q),
    .piece_i    (cur),
    .wdata_i    (wdata_q),
    .rdata_i    (bus_rdata_i),
    .acc_i      (acc_q),
    .wdata_o    (lane_wdata),
    .acc_next_o (acc_next)
  );

  assign req_ready_o = !busy;
  assign bus_valid_o = busy;
  assign bus_addr_o  = addr_q + AW'(cur.off);
  assign bus_size_o  = cur.sz;
  assign bus_we_o    = busy && we_q;
  assign bus_wdata_o = we_q ? lane_wdata : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      plan_q  <= '0;
      eff_q   <= SZ_BYTE;
      acc_q   <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= last_hs;
      if (accept) begin
        addr_q  <= req_addr_i;
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
        plan_q  <= plan_d;
        eff_q   <= eff_d;
        acc_q   <= '0;
      end else if (hs && !we_q) begin
        acc_q <= acc_next;
      end
      if (last_hs) rdata_o <= we_q ? '0 : acc_next;
    end
  end
endmodule

// File: rtl/acc_splitter_chk.sv
module acc_splitter_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [AW-1:0] req_addr_i,
  input logic [1:0]    req_size_i,
  input logic          bus_valid_o,
  input logic          bus_ready_i,
  input logic [AW-1:0] bus_addr_o,
  input logic [1:0]    bus_size_o,
  input logic          bus_we_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          done_o
);
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> !req_ready_o);  // R1

  AST_BYTE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_size_i == 2'd0) |=>
      (bus_valid_o && bus_size_o == 2'd0 && bus_addr_o == $past(req_addr_i)));  // R2

  AST_BUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_ready_i) |=>
      (bus_valid_o && $stable(bus_addr_o) && $stable(bus_size_o) &&
       $stable(bus_we_o) && $stable(bus_wdata_o)));  // R9

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R10

  AST_DONE_AFTER_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bus_valid_o && bus_ready_i));  // R10

  AST_WORD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_size_o == 2'd1) |-> !bus_addr_o[0]);  // R11

  AST_LONG_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_size_o == 2'd2) |-> (bus_addr_o[1:0] == 2'b00));  // R11

  AST_SIZE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> (bus_size_o != 2'd3));  // R11
endmodule

bind acc_splitter acc_splitter_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_addr_i  (req_addr_i),
  .req_size_i  (req_size_i),
  .bus_valid_o (bus_valid_o),
  .bus_ready_i (bus_ready_i),
  .bus_addr_o  (bus_addr_o),
  .bus_size_o  (bus_size_o),
  .bus_we_o    (bus_we_o),
  .bus_wdata_o (bus_wdata_o),
  .done_o      (done_o)
);

// File: tb/acc_splitter_tb.sv
module acc_splitter_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic        req_we_i = 1'b0;
  logic [31:0] req_wdata_i = '0;
  logic        bus_valid_o;
  logic        bus_ready_i = 1'b0;
  logic [31:0] bus_addr_o;
  logic [1:0]  bus_size_o;
  logic        bus_we_o;
  logic [31:0] bus_wdata_o;
  logic [31:0] bus_rdata_i = '0;
  logic        done_o;
  logic [31:0] rdata_o;

  always #10 clk = ~clk;

  acc_splitter u_dut (
    .clk_i (clk), .rst_ni (rst_ni),
    .req_valid_i (req_valid_i), .req_ready_o (req_ready_o),
    .req_addr_i (req_addr_i), .req_size_i (req_size_i),
    .req_we_i (req_we_i), .req_wdata_i (req_wdata_i),
    .bus_valid_o (bus_valid_o), .bus_ready_i (bus_ready_i),
    .bus_addr_o (bus_addr_o), .bus_size_o (bus_size_o),
    .bus_we_o (bus_we_o), .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i), .done_o (done_o), .rdata_o (rdata_o)
  );

  typedef struct {
    logic [31:0] addr;
    logic [1:0]  sz;
    logic        we;
    logic [31:0] wd;
    string       rq;
  } bus_exp_t;

  typedef struct {
    logic [31:0] rd;
    string       rq;
  } done_exp_t;

  bus_exp_t  bus_q[$];
  done_exp_t done_q[$];
  logic [7:0] mem [256];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [31:0] lane_mask(int s);
    case (s)
      1:       lane_mask = 32'h0000_00ff;
      2:       lane_mask = 32'h0000_ffff;
      default: lane_mask = 32'hffff_ffff;
    endcase
  endfunction

  // driver: pushes expected bus cycles and completion, then issues the request
  task automatic do_req(input logic [31:0] a, input logic [1:0] sz, input logic we,
                        input logic [31:0] wd, input string rq);
    int nb;
    int np;
    int offs[3];
    int szs[3];
    logic [31:0] rv;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    np = 1; offs[0] = 0; szs[0] = nb;
    if (nb == 2 && a[0]) begin
      np = 2; offs[0] = 0; szs[0] = 1; offs[1] = 1; szs[1] = 1;
    end else if (nb == 4 && a[1:0] == 2'd2) begin
      np = 2; offs[0] = 0; szs[0] = 2; offs[1] = 2; szs[1] = 2;
    end else if (nb == 4 && a[0]) begin
      np = 3; offs[0] = 0; szs[0] = 1; offs[1] = 1; szs[1] = 2; offs[2] = 3; szs[2] = 1;
    end
    for (int k = 0; k < np; k++) begin
      bus_exp_t e;
      e.addr = a + 32'(offs[k]);
      e.sz   = (szs[k] == 1) ? 2'd0 : (szs[k] == 2) ? 2'd1 : 2'd2;
      e.we   = we;
      e.wd   = we ? ((wd >> (8 * (nb - offs[k] - szs[k]))) & lane_mask(szs[k])) : 32'h0;
      e.rq   = rq;
      bus_q.push_back(e);
    end
    rv = '0;
    for (int i = 0; i < nb; i++) rv = (rv << 8) | 32'(mem[8'(a + 32'(i))]);
    done_q.push_back('{rd: (we ? 32'h0 : rv), rq: rq});
    req_addr_i = a; req_size_i = sz; req_we_i = we; req_wdata_i = wd;
    req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    check(!req_ready_o, "R1", "ready low after accept", 32'(req_ready_o), 32'h0);
    while (!done_o) @(negedge clk);
  endtask

  // bus model and bus-side monitor
  initial begin
    int wait_n;
    int wait_pat;
    bit stalled;
    logic [31:0] s_addr, s_wd;
    logic [2:0]  s_ctl;
    wait_n = 0; wait_pat = 1; stalled = 0;
    s_addr = '0; s_wd = '0; s_ctl = '0;
    forever begin
      @(negedge clk);
      if (bus_ready_i) begin
        bus_ready_i = 1'b0;
        wait_n = wait_pat;
        wait_pat = (wait_pat + 1) % 3;
        stalled = 0;
      end else if (bus_valid_o) begin
        check(!req_ready_o, "R1", "ready low during bus cycle", 32'(req_ready_o), 32'h0);
        if (stalled) begin
          check(bus_addr_o == s_addr, "R9", "addr held in stall", bus_addr_o, s_addr);
          check({bus_we_o, bus_size_o} == s_ctl, "R9", "ctl held in stall",
                32'({bus_we_o, bus_size_o}), 32'(s_ctl));
          check(bus_wdata_o == s_wd, "R9", "wdata held in stall", bus_wdata_o, s_wd);
        end
        if (wait_n == 0) begin
          if (bus_q.size() == 0) begin
            check(1'b0, "R2", "unexpected bus cycle", bus_addr_o, 32'h0);
          end else begin
            bus_exp_t e;
            int s;
            logic [31:0] v;
            e = bus_q.pop_front();
            check(bus_addr_o == e.addr, e.rq, "bus addr", bus_addr_o, e.addr);
            check({bus_we_o, bus_size_o} == {e.we, e.sz}, e.rq, "bus we/size",
                  32'({bus_we_o, bus_size_o}), 32'({e.we, e.sz}));
            check(bus_wdata_o == e.wd, e.we ? "R8" : e.rq, "bus wdata", bus_wdata_o, e.wd);
          end
          begin
            int s;
            logic [31:0] v;
            s = (bus_size_o == 2'd0) ? 1 : (bus_size_o == 2'd1) ? 2 : 4;
            v = '0;
            for (int i = 0; i < s; i++) v = (v << 8) | 32'(mem[8'(bus_addr_o + 32'(i))]);
            if (bus_we_o)
              for (int i = 0; i < s; i++)
                mem[8'(bus_addr_o + 32'(i))] = 8'(bus_wdata_o >> (8 * (s - 1 - i)));
            bus_rdata_i = (32'ha5a5_a5a5 << (8 * s)) | v;
          end
          bus_ready_i = 1'b1;
        end else begin
          wait_n--;
          if (!stalled) begin
            s_addr = bus_addr_o; s_wd = bus_wdata_o; s_ctl = {bus_we_o, bus_size_o};
            stalled = 1;
          end
        end
      end
    end
  end

  // completion monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done_o) begin
        check(req_ready_o, "R1", "ready back at done", 32'(req_ready_o), 32'h1);
        check(bus_q.size() == 0, "R10", "all cycles done before done", 32'(bus_q.size()), 32'h0);
        if (done_q.size() == 0) begin
          check(1'b0, "R10", "unexpected done", 32'h1, 32'h0);
        end else begin
          done_exp_t d;
          d = done_q.pop_front();
          check(rdata_o == d.rd, (d.rd == 32'h0) ? "R10" : "R7", {d.rq, " read data"},
                rdata_o, d.rd);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    check(req_ready_o == 1'b1, "R13", "ready in reset", 32'(req_ready_o), 32'h1);
    check(bus_valid_o == 1'b0, "R13", "bus idle in reset", 32'(bus_valid_o), 32'h0);
    check(done_o == 1'b0, "R13", "done low in reset", 32'(done_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    do_req(32'h0000_0010, 2'd0, 1'b0, 32'h0, "R2");
    do_req(32'h0000_0013, 2'd0, 1'b0, 32'h0, "R2");
    do_req(32'h0000_0020, 2'd1, 1'b0, 32'h0, "R3");
    do_req(32'h0000_0030, 2'd2, 1'b0, 32'h0, "R3");
    do_req(32'h0000_0021, 2'd1, 1'b0, 32'h0, "R4");
    do_req(32'h0000_0032, 2'd2, 1'b0, 32'h0, "R5");
    do_req(32'h0000_0031, 2'd2, 1'b0, 32'h0, "R6");
    do_req(32'h0000_0033, 2'd2, 1'b0, 32'h0, "R6");
    do_req(32'h0000_0045, 2'd3, 1'b0, 32'h0, "R12");
    do_req(32'h0000_004a, 2'd3, 1'b0, 32'h0, "R12");

    do_req(32'h0000_0051, 2'd2, 1'b1, 32'h1122_3344, "R6");
    do_req(32'h0000_0050, 2'd2, 1'b0, 32'h0, "R7");
    do_req(32'h0000_0052, 2'd1, 1'b0, 32'h0, "R7");
    do_req(32'h0000_0062, 2'd2, 1'b1, 32'ha1b2_c3d4, "R5");
    do_req(32'h0000_0063, 2'd1, 1'b0, 32'h0, "R7");
    do_req(32'h0000_0071, 2'd1, 1'b1, 32'hffff_5aa5, "R4");
    do_req(32'h0000_0070, 2'd2, 1'b0, 32'h0, "R7");
    do_req(32'h0000_0080, 2'd0, 1'b1, 32'hffff_ff9c, "R8");
    do_req(32'h0000_0080, 2'd0, 1'b0, 32'h0, "R7");
    do_req(32'h0000_00fd, 2'd2, 1'b1, 32'hdead_beef, "R6");
    do_req(32'h0000_00fe, 2'd1, 1'b0, 32'h0, "R7");
    do_req(32'h0000_00fd, 2'd3, 1'b0, 32'h0, "R12");
    do_req(32'h0000_0094, 2'd2, 1'b1, 32'h0bad_f00d, "R3");
    do_req(32'h0000_0095, 2'd2, 1'b0, 32'h0, "R6");

    repeat (3) @(negedge clk);
    check(bus_q.size() == 0, "R10", "bus queue drained", 32'(bus_q.size()), 32'h0);
    check(done_q.size() == 0, "R10", "done queue drained", 32'(done_q.size()), 32'h0);
    check(req_ready_o && !bus_valid_o, "R1", "idle at end",
          32'({req_ready_o, bus_valid_o}), 32'h2);
    summary();
  end
endmodule